// File: doc/BRIEF.md
# PS/2 Receive Port with Polled Byte Queue

This block takes the two open-collector lines of a PS/2 keyboard or mouse, already seen as plain logic inputs, and recovers each byte the device sends. Every byte that arrives intact goes, unchanged, into a small first-in first-out queue on chip. The block does not translate, decode or track key state, so the same port also carries mouse packets. Only one device is attached at a time.

The host never gets an interrupt. Instead it polls a two-address read bus. The status address reports whether the queue is empty or full, and a sticky overrun flag. The data address returns the oldest byte and removes it.

The bus is the only way out, and it has no back-pressure. A PS/2 device cannot be stalled. When a byte completes while the queue is full, that byte is dropped and the overrun flag is raised.

Top module: `ps2_poll_rx`

## Requirements
- R1: After reset the status read returns 0x01 and the queue holds no byte. Status layout: bit 0 empty, bit 1 full, bit 2 overrun, bits 7:3 zero.
- R2: A frame with a low start bit, eight data bits least significant first, an odd parity bit and a high stop bit stores its data byte unchanged. Bytes come out in arrival order.
- R3: A bus read with address 1 returns the oldest stored byte and removes it. A read with address 0 leaves the queue unchanged.
- R4: The queue holds DEPTH bytes (16 by default). With DEPTH bytes stored, status bit 1 is 1.
- R5: A byte that completes while DEPTH bytes are stored is discarded, and the bytes already stored are unaffected. The overrun bit then reads 1.
- R6: The overrun bit stays set until a status read. That read still returns it as 1, and the next status read returns it as 0.
- R7: A frame whose parity bit makes the count of ones over data and parity even is dropped.
- R8: A frame whose stop bit is low is dropped.
- R9: A data read on an empty queue returns 0x00 and does not move the read position. A byte that arrives later is read back correctly.
- R10: If no falling device-clock edge appears for TIMEOUT_CYC cycles inside a frame, the partial frame is abandoned. The next complete frame is received correctly.
- R11: A device-clock pulse that lasts fewer than FILT_LEN system cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ps2_clk_i | input | 1 | Device clock line, asynchronous |
| ps2_dat_i | input | 1 | Device data line, asynchronous |
| bus_rd_i | input | 1 | Read strobe; the pop or flag clear happens at the clock edge where it is high |
| bus_addr_i | input | 1 | 0 selects status, 1 selects data |
| bus_rdata_o | output | 8 | Read data for the selected address, valid in the cycle of the strobe |

## Verification
The assertions assume the following about the inputs:
- The device clock holds each level for well over FILT_LEN system cycles.
- The data line changes only while the device clock is high, so data is settled at each falling edge.
- Bus strobes may arrive in any cycle.

The stimulus follows these rules. It uses half-periods of twelve cycles against a filter of four, and it moves the data line one half-period before each falling edge. The only deliberate breaks are a two-cycle glitch and a frame left unfinished for the timeout. Both of these are the cases the filter and the watchdog are there to absorb.

// File: rtl/ps2q_pkg.sv
package ps2q_pkg;
  typedef enum logic {REG_STAT = 1'b0, REG_DATA = 1'b1} reg_sel_e;
  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_OVR   = 2;
  localparam int FRAME_LAST = 10;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_raw_i,
  input  logic dat_raw_i,
  output logic dat_o,
  output logic fall_o
);
  logic [1:0] clk_sync, dat_sync;
  logic [FILT_LEN-1:0] hist;
  logic filt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sync <= 2'b11;
      dat_sync <= 2'b11;
      hist     <= '1;
      filt     <= 1'b1;
      fall_o   <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[0], clk_raw_i};
      dat_sync <= {dat_sync[0], dat_raw_i};
      hist     <= {hist[FILT_LEN-2:0], clk_sync[1]};
      fall_o   <= 1'b0;
      if (&hist) filt <= 1'b1;
      else if (~|hist) begin
        filt   <= 1'b0;
        fall_o <= filt;
      end
    end
  end

  assign dat_o = dat_sync[1];

  // A falling edge is only reported after a full window of low samples
  p_fall_needs_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(clk_sync[1]) == 1'b0);
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2q_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       valid_o,
  output logic [7:0] byte_o
);
  localparam int WD_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_CYC - 1);

  logic [3:0]      bit_cnt;
  logic [7:0]      shreg;
  logic            par;
  logic [WD_W-1:0] wd_cnt;
  logic            frame_ok;

  assign frame_ok = dat_i && (^{shreg, par});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      par     <= 1'b0;
      wd_cnt  <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i) begin
        wd_cnt <= '0;
        if (bit_cnt == 4'd0) begin
          if (!dat_i) bit_cnt <= 4'd1;
        end else if (bit_cnt <= 4'd8) begin
          shreg   <= {dat_i, shreg[7:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd9) begin
          par     <= dat_i;
          bit_cnt <= 4'd10;
        end else begin
          bit_cnt <= 4'd0;
          if (frame_ok) begin
            valid_o <= 1'b1;
            byte_o  <= shreg;
          end
        end
      end else if (bit_cnt != 4'd0) begin
        if (wd_cnt == WD_LAST) begin
          bit_cnt <= 4'd0;
          wd_cnt  <= '0;
        end else begin
          wd_cnt <= wd_cnt + 1'b1;
        end
      end else begin
        wd_cnt <= '0;
      end
    end
  end

  p_bit_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'(FRAME_LAST));
  p_bad_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && bit_cnt == 4'd10 && !(^{shreg, par})) |=> !valid_o);
  p_bad_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && bit_cnt == 4'd10 && !dat_i) |=> !valid_o);
  p_watchdog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_i && bit_cnt != 4'd0 && wd_cnt == WD_LAST) |=> bit_cnt == 4'd0);
endmodule

// File: rtl/ps2_byte_fifo.sv
module ps2_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic [7:0] wdata_i,
  input  logic       pop_i,
  input  logic       clr_ovr_i,
  output logic [7:0] rdata_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       ovr_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_LVL);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = empty_o ? 8'h00 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_o  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && !push_ok) ovr_o <= 1'b1;
      else if (clr_ovr_i)     ovr_o <= 1'b0;
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_LVL);
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> ovr_o);
  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr_i && !(push_i && full_o)) |=> !ovr_o);
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o && $stable(rd_ptr));
endmodule

// File: rtl/ps2_poll_rx.sv
module ps2_poll_rx
  import ps2q_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       bus_rd_i,
  input  logic       bus_addr_i,
  output logic [7:0] bus_rdata_o
);
  logic       dat_s, fall_s, rx_valid, q_empty, q_full, q_ovr;
  logic [7:0] rx_byte, q_data, stat;
  reg_sel_e   sel;

  assign sel = reg_sel_e'(bus_addr_i);

  ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .clk_raw_i(ps2_clk_i), .dat_raw_i(ps2_dat_i),
    .dat_o(dat_s), .fall_o(fall_s));

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_s), .dat_i(dat_s),
    .valid_o(rx_valid), .byte_o(rx_byte));

  ps2_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(rx_valid), .wdata_i(rx_byte),
    .pop_i(bus_rd_i && sel == REG_DATA),
    .clr_ovr_i(bus_rd_i && sel == REG_STAT),
    .rdata_o(q_data), .empty_o(q_empty), .full_o(q_full), .ovr_o(q_ovr));

  always_comb begin
    stat = '0;
    stat[ST_EMPTY] = q_empty;
    stat[ST_FULL]  = q_full;
    stat[ST_OVR]   = q_ovr;
  end

  assign bus_rdata_o = (sel == REG_DATA) ? q_data : stat;

  p_empty_full_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));
endmodule

// File: tb/test_ps2_poll_rx.sv
module test_ps2_poll_rx;
  localparam int HALF = 12;
  localparam int TMO  = 300;
  localparam int DEP  = 16;
  // {bad_parity, bad_stop, byte}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 8'h1C}, {2'b00, 8'hF0}, {2'b00, 8'h00}, {2'b00, 8'hFF},
    {2'b10, 8'hAA}, {2'b01, 8'h55}, {2'b00, 8'h81}, {2'b00, 8'h7E}};

  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b1, pdat = 1'b1;
  logic rd = 1'b0, addr = 1'b0;
  logic [7:0] rdata, got;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ps2_poll_rx #(.DEPTH(DEP), .FILT_LEN(4), .TIMEOUT_CYC(TMO)) i_ps2_poll_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
    .bus_rd_i(rd), .bus_addr_i(addr), .bus_rdata_o(rdata));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    pdat = b;
    repeat (HALF) @(negedge clk);
    pclk = 1'b0;
    repeat (HALF) @(negedge clk);
    pclk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit((~^b) ^ bad_par);
    send_bit(~bad_stop);
    pdat = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    bus_read(1'b0, got); chk(got, 8'h01, "R1 status after reset");
    // R9 empty data read
    bus_read(1'b1, got); chk(got, 8'h00, "R9 empty data read");

    // vector table: R2 R3 R7 R8
    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][7:0], VEC[v][9], VEC[v][8]);
      if (VEC[v][9:8] == 2'b00) begin
        bus_read(1'b0, got); chk(got, 8'h00, "R3 status non-empty, no pop");
        bus_read(1'b1, got); chk(got, VEC[v][7:0], "R2 stored byte");
      end else begin
        bus_read(1'b1, got);
        chk(got, 8'h00, VEC[v][9] ? "R7 bad parity dropped" : "R8 bad stop dropped");
      end
      bus_read(1'b0, got); chk(got, 8'h01, "R3 empty after pop");
    end

    // R4 fill, R5 overrun, R6 clear
    for (int i = 0; i < DEP; i++) send_frame(8'(8'h30 + i), 1'b0, 1'b0);
    bus_read(1'b0, got); chk(got, 8'h02, "R4 full after DEPTH bytes");
    send_frame(8'hEE, 1'b0, 1'b0);
    bus_read(1'b0, got); chk(got, 8'h06, "R5 overrun set when full");
    bus_read(1'b0, got); chk(got, 8'h02, "R6 overrun cleared by status read");
    for (int i = 0; i < DEP; i++) begin
      bus_read(1'b1, got); chk(got, 8'(8'h30 + i), "R5 stored bytes intact in order");
    end
    bus_read(1'b0, got); chk(got, 8'h01, "R3 empty after draining");

    // R9 pointer unchanged by empty reads
    bus_read(1'b1, got); chk(got, 8'h00, "R9 empty read 1");
    bus_read(1'b1, got); chk(got, 8'h00, "R9 empty read 2");
    send_frame(8'hC3, 1'b0, 1'b0);
    bus_read(1'b1, got); chk(got, 8'hC3, "R9 byte after empty reads");

    // R10 watchdog abandons partial frame
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    pdat = 1'b1;
    repeat (TMO + 100) @(negedge clk);
    send_frame(8'h5A, 1'b0, 1'b0);
    bus_read(1'b1, got); chk(got, 8'h5A, "R10 frame after timeout");
    bus_read(1'b0, got); chk(got, 8'h01, "R10 nothing extra stored");

    // R11 short glitch ignored
    pdat = 1'b0;
    repeat (HALF) @(negedge clk);
    pclk = 1'b0;
    repeat (2) @(negedge clk);
    pclk = 1'b1;
    repeat (30) @(negedge clk);
    pdat = 1'b1;
    repeat (30) @(negedge clk);
    send_frame(8'h3C, 1'b0, 1'b0);
    bus_read(1'b1, got); chk(got, 8'h3C, "R11 glitch ignored");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule